// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block works out the operand of an instruction from its addressing mode. A start strobe brings in a three-bit mode code, a register index and a 32-bit constant from the instruction. The block then reads the named register, memory, or both, and returns the final operand together with the effective address it used. A one-cycle done strobe marks the cycle in which both results are valid.

There are six modes. Two need no memory: the register value or the constant is the operand. Three make a single memory read, at the constant, at the register value, or at the sum of the two. The memory-indirect mode makes two dependent reads: the first fetches a pointer and the second fetches the operand at that pointer.

The register file is outside the block. The block presents the register index on `rf_addr`, and the register file returns that register's contents combinationally on `rf_rdata` in the same cycle. Memory reads use a request pulse followed by a response strobe, which may arrive any number of cycles later.

Top module: `opnd_resolver`

## Requirements
- R1: Mode code 0 (register). The operand is the contents of the register named by `reg_sel`. `done` is high in the cycle after start is accepted, `ea` is 0, `err` is 0, and no memory request is issued.
- R2: Mode code 1 (immediate). The operand is `cst`. `done` is high in the cycle after start is accepted, `ea` is 0, `err` is 0, and no memory request is issued.
- R3: Mode code 2 (absolute). The block makes exactly one memory read at address `cst`. The operand is the returned data and `ea` equals `cst`.
- R4: Mode code 3 (register indirect). The block makes exactly one memory read at the address held in the named register. The operand is the returned data and `ea` is that register's value.
- R5: Mode code 4 (memory indirect). The block makes two reads in sequence: the first at `cst`, the second at the data returned by the first. `ea` is that pointer and the operand is the data returned by the second read.
- R6: Mode code 5 (indexed). The block makes one read at `cst` plus the register value, wrapped modulo 2^32. That sum is `ea` and the returned data is the operand.
- R7: `mem_req` is high for exactly one cycle per read, with `mem_addr` valid in that cycle. The block waits any number of cycles for `mem_rvalid`. `done` rises in the cycle after the final response is sampled.
- R8: Mode codes 6 and 7 are unused. They complete in the cycle after start with `err` = 1, operand 0 and `ea` 0, and issue no memory request.
- R9: A start strobe that arrives while a resolution is in progress is ignored. It produces no extra `done`, and it does not change the result of the resolution already in progress.
- R10: While reset is held, `done`, `mem_req` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a resolution (accepted only when idle) |
| mode | input | 3 | Addressing-mode code |
| reg_sel | input | 3 | Register index from the instruction |
| cst | input | 32 | Constant or address field from the instruction |
| rf_addr | output | 3 | Register index presented to the register file |
| rf_rdata | input | 32 | Contents of register `rf_addr` (combinational) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| ea | output | 32 | Effective address of the last resolution |
| operand | output | 32 | Resolved operand value |
| done | output | 1 | One-cycle strobe: `ea`, `operand` and `err` are valid |
| err | output | 1 | Unused mode code seen |

## Verification
The hardest case to reach from the ports is the memory-indirect chain. There, the address of the second read is the data returned by the first, and a start strobe may land in the middle of the chain. The bench's memory model answers each request with data that is a scrambled function of its address, after a latency that changes from test to test. The expected operand is therefore the function applied twice, and a wrong second address shows up in the result. The bench also pulses start again partway through a chain, with a different mode and constant. It then checks that the result is unchanged and that no extra done strobe appears.

// File: rtl/opnd_pkg.sv
// Shared types for the operand resolver.
// Assumes the mode field of an instruction is three bits wide.
package opnd_pkg;

    typedef enum logic [2:0] {
        AM_REG  = 3'd0,
        AM_IMM  = 3'd1,
        AM_ABS  = 3'd2,
        AM_RIND = 3'd3,
        AM_MIND = 3'd4,
        AM_IDX  = 3'd5
    } amode_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REQ1  = 3'd1,
        PH_WAIT1 = 3'd2,
        PH_REQ2  = 3'd3,
        PH_WAIT2 = 3'd4
    } phase_e;

endpackage

// File: rtl/opnd_ea_gen.sv
// Decodes the addressing mode into a first memory address, a direct value,
// and flags that say whether memory is needed and whether two reads chain.
// Assumes rf_val is the contents of the selected register in this cycle.
module opnd_ea_gen
    import opnd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2:0]    mode_i,
    input  logic [DW-1:0] cst_i,
    input  logic [DW-1:0] rf_val_i,
    output logic [DW-1:0] first_addr_o,
    output logic [DW-1:0] direct_o,
    output logic          needs_mem_o,
    output logic          chain_o,
    output logic          illegal_o
);

    // Mode decode and indexed address sum (wraps modulo 2^DW)
    always_comb begin
        first_addr_o = '0;
        direct_o     = '0;
        needs_mem_o  = 1'b0;
        chain_o      = 1'b0;
        illegal_o    = 1'b0;
        case (mode_i)
            AM_REG:  direct_o = rf_val_i;
            AM_IMM:  direct_o = cst_i;
            AM_ABS:  begin first_addr_o = cst_i;            needs_mem_o = 1'b1; end
            AM_RIND: begin first_addr_o = rf_val_i;         needs_mem_o = 1'b1; end
            AM_MIND: begin first_addr_o = cst_i;            needs_mem_o = 1'b1; chain_o = 1'b1; end
            AM_IDX:  begin first_addr_o = cst_i + rf_val_i; needs_mem_o = 1'b1; end
            default: illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/opnd_seq.sv
// Sequencer for the resolver: idle, up to two request/wait pairs.
// Assumes a memory response never arrives in the cycle its request is raised.
module opnd_seq
    import opnd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   needs_mem_i,
    input  logic   chain_i,
    input  logic   rvalid_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   grab_ptr_o,
    output logic   finish_o
);

    phase_e phase_q, phase_d;
    logic   chain_q;

    assign phase_o    = phase_q;
    assign accept_o   = (phase_q == PH_IDLE) && start_i;
    assign grab_ptr_o = (phase_q == PH_WAIT1) && rvalid_i && chain_q;
    assign finish_o   = (accept_o && !needs_mem_i)
                      || ((phase_q == PH_WAIT1) && rvalid_i && !chain_q)
                      || ((phase_q == PH_WAIT2) && rvalid_i);

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (accept_o && needs_mem_i) phase_d = PH_REQ1;
            PH_REQ1:  phase_d = PH_WAIT1;
            PH_WAIT1: if (rvalid_i) phase_d = chain_q ? PH_REQ2 : PH_IDLE;
            PH_REQ2:  phase_d = PH_WAIT2;
            PH_WAIT2: if (rvalid_i) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase and chain-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            chain_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept_o) chain_q <= chain_i;
        end
    end

    // R7
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_REQ1 || phase_q == PH_REQ2) |=> (phase_q == PH_WAIT1 || phase_q == PH_WAIT2));

endmodule

// File: rtl/opnd_resolver.sv
// Operand resolver top: latches the first address or direct value on start,
// runs the memory reads through opnd_seq, and presents ea/operand with done.
// Assumes an external register file answers rf_addr combinationally.
module opnd_resolver
    import opnd_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     mode,
    input  logic [RSW-1:0] reg_sel,
    input  logic [DW-1:0]  cst,
    output logic [RSW-1:0] rf_addr,
    input  logic [DW-1:0]  rf_rdata,
    output logic           mem_req,
    output logic [DW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  ea,
    output logic [DW-1:0]  operand,
    output logic           done,
    output logic           err
);

    logic [DW-1:0] first_addr, direct_val;
    logic          needs_mem, chain, illegal;
    phase_e        phase;
    logic          accept, grab_ptr, finish;
    logic [DW-1:0] addr_q, opnd_q;
    logic          done_q, err_q;

    assign rf_addr  = reg_sel;
    assign mem_req  = (phase == PH_REQ1) || (phase == PH_REQ2);
    assign mem_addr = addr_q;
    assign ea       = addr_q;
    assign operand  = opnd_q;
    assign done     = done_q;
    assign err      = err_q;

    opnd_ea_gen #(.DW(DW)) u_ea (
        .mode_i       (mode),
        .cst_i        (cst),
        .rf_val_i     (rf_rdata),
        .first_addr_o (first_addr),
        .direct_o     (direct_val),
        .needs_mem_o  (needs_mem),
        .chain_o      (chain),
        .illegal_o    (illegal)
    );

    opnd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .needs_mem_i (needs_mem),
        .chain_i     (chain),
        .rvalid_i    (mem_rvalid),
        .phase_o     (phase),
        .accept_o    (accept),
        .grab_ptr_o  (grab_ptr),
        .finish_o    (finish)
    );

    // Address, operand, done and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            opnd_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                err_q  <= illegal;
                addr_q <= first_addr;
                if (!needs_mem) opnd_q <= direct_val;
            end else if (grab_ptr) begin
                addr_q <= mem_rdata;
            end else if (finish) begin
                opnd_q <= mem_rdata;
            end
        end
    end

    // R1
    reg_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start && mode == AM_REG) |=> (done && !err && !mem_req));

    // R8
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (operand == '0 && ea == '0 && !mem_req));

    // R9
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> !done);

    // R10
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !err));

endmodule

// File: tb/opnd_resolver_test.sv
module opnd_resolver_test;
    import opnd_pkg::*;

    typedef struct {
        logic [31:0] opnd;
        logic [31:0] ea;
        logic        err;
        int          nreq;
        int          lat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] cst = '0;
    logic [2:0]  rf_addr;
    logic [31:0] rf_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] ea, operand;
    logic        done, err;

    logic [31:0] rf [8];
    exp_t        sb[$];
    int          tests = 0, fails = 0;
    int          edges = 0, t0 = 0, reqs = 0, dones = 0;
    int          mlat = 1;
    int          cd = 0;
    logic [31:0] paddr = '0;

    always #2 clk = ~clk;

    assign rf_rdata = rf[rf_addr];

    opnd_resolver uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_sel(reg_sel),
        .cst(cst), .rf_addr(rf_addr), .rf_rdata(rf_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ea(ea), .operand(operand), .done(done), .err(err)
    );

    function automatic logic [31:0] mfun(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h3C3C_C3C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    always @(posedge clk) edges++;

    // memory model with per-test latency
    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mfun(paddr);
            end
        end
        if (rst_n && mem_req) begin
            paddr = mem_addr;
            cd    = mlat;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) reqs++;
            if (done) begin
                dones++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'(dones), 32'(dones - 1));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(operand == e.opnd, {e.tag, " operand"}, operand, e.opnd);
                    chk(ea == e.ea, {e.tag, " ea"}, ea, e.ea);
                    chk(err == e.err, {e.tag, " err"}, 32'(err), 32'(e.err));
                    chk(reqs == e.nreq, {e.tag, " reads"}, 32'(reqs), 32'(e.nreq));
                    chk((edges - t0) == e.lat, {e.tag, " R7 latency"}, 32'(edges - t0), 32'(e.lat));
                end
                reqs = 0;
            end
        end
    end

    task automatic run_op(input logic [2:0] m, input logic [2:0] s, input logic [31:0] c,
                          input int lat, input string tag, input bit interrupt);
        exp_t e;
        logic [31:0] r, p;
        r = rf[s];
        e.tag = tag; e.err = 1'b0; e.ea = '0; e.opnd = '0; e.nreq = 0; e.lat = 1;
        case (m)
            3'd0: e.opnd = r;
            3'd1: e.opnd = c;
            3'd2: begin e.ea = c; e.opnd = mfun(c); e.nreq = 1; e.lat = lat + 2; end
            3'd3: begin e.ea = r; e.opnd = mfun(r); e.nreq = 1; e.lat = lat + 2; end
            3'd4: begin p = mfun(c); e.ea = p; e.opnd = mfun(p); e.nreq = 2; e.lat = 2*lat + 3; end
            3'd5: begin e.ea = c + r; e.opnd = mfun(c + r); e.nreq = 1; e.lat = lat + 2; end
            default: e.err = 1'b1;
        endcase
        sb.push_back(e);
        @(negedge clk);
        mlat = lat;
        mode = m; reg_sel = s; cst = c; start = 1'b1; t0 = edges;
        @(negedge clk);
        start = 1'b0;
        if (interrupt) begin
            @(negedge clk);
            mode = 3'd1; cst = 32'hDEAD_0001; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(posedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0110;
        rf[6] = 32'h0000_0020;
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !err, "R10 reset outputs", {29'd0, done, mem_req, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(3'd0, 3'd3, 32'h0, 1, "R1 register", 1'b0);
        run_op(3'd1, 3'd2, 32'hCAFE_F00D, 1, "R2 immediate", 1'b0);
        run_op(3'd2, 3'd0, 32'h0000_4444, 1, "R3 absolute lat1", 1'b0);
        run_op(3'd2, 3'd0, 32'h1234_5678, 3, "R3 absolute lat3", 1'b0);
        run_op(3'd3, 3'd5, 32'hFFFF_0000, 2, "R4 register indirect", 1'b0);
        run_op(3'd4, 3'd1, 32'h0000_0BAD, 2, "R5 memory indirect", 1'b0);
        run_op(3'd4, 3'd7, 32'h7777_1111, 4, "R5 memory indirect lat4", 1'b0);
        run_op(3'd5, 3'd2, 32'h0000_0100, 1, "R6 indexed", 1'b0);
        run_op(3'd5, 3'd6, 32'hFFFF_FFF0, 2, "R6 indexed wrap", 1'b0);
        run_op(3'd6, 3'd1, 32'h5555_5555, 1, "R8 unused code 6", 1'b0);
        run_op(3'd7, 3'd1, 32'h5555_5555, 1, "R8 unused code 7", 1'b0);
        run_op(3'd4, 3'd4, 32'h0000_2222, 3, "R9 start while busy", 1'b1);
        repeat (6) @(negedge clk);
        chk(dones == 12, "R9 done count", 32'(dones), 32'd12);
        run_op(3'd1, 3'd0, 32'h0000_00AB, 1, "R2 after busy", 1'b0);
        run_op(3'd0, 3'd6, 32'h0, 1, "R1 back to back", 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule